// File: doc/BRIEF.md
# Single-Operand Byte ALU with Destination Routing

This block performs one of four single-operand byte operations and routes the result either to the working register or back to the addressed file register. The four operations are: clear a file register, clear the working register, bitwise invert a file register value, and subtract one from a file register value. Every operation also produces a zero-flag update. Storing the register file, selecting banks and handling any other operation are left to the surrounding datapath. The surrounding datapath supplies the value it has read from the addressed file register along with the command.

Commands arrive on a valid/ready stream. The block holds one result in an output register and presents it on a valid/ready result stream. A command is accepted on a clock edge where `in_valid` and `in_ready` are both high. That edge is the execute strobe, and the computed result appears on the next cycle. `in_ready` is high whenever the output register is empty, or whenever it is being emptied in the same cycle. This gives full throughput with no bubble. When the consumer holds `out_ready` low, back-pressure stops further intake, and the pending result holds steady until it is taken.

Top module: `fra_alu`

## Requirements
- R1: Op code 0 (clear file) yields `f_we`=1, `f_wdata`=00h, `w_we`=0 and `z_val`=1, whatever the destination bit.
- R2: Op code 1 (clear W) yields `w_we`=1, `w_wdata`=00h, `f_we`=0 and `z_val`=1, whatever the destination bit.
- R3: Op code 2 (invert) yields the bitwise complement of `in_fdata`. It goes to W (`w_we`=1) when `in_dest`=0 and to the file register (`f_we`=1) when `in_dest`=1.
- R4: Op code 3 (decrement) yields `in_fdata` minus one, modulo 256, so 00h becomes FFh. It follows the same destination rule as R3.
- R5: With every result, `z_we`=1, and `z_val` is 1 exactly when the 8-bit result is 00h.
- R6: While `out_valid` is high, exactly one of `f_we` and `w_we` is high. While `out_valid` is low, `f_we`, `w_we` and `z_we` are all low.
- R7: `f_addr` carries the 7-bit address given with the accepted command.
- R8: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, the result and `out_valid` hold unchanged on the next cycle.
- R9: During and right after reset, `out_valid` is low.
- R10: A command accepted on one clock edge sets `out_valid` on the following cycle, carrying that command's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Command valid |
| in_ready | output | 1 | Command can be taken |
| in_op | input | 2 | Op code: 0 clear file, 1 clear W, 2 invert, 3 decrement |
| in_addr | input | ADDR_W (7) | File register address |
| in_dest | input | 1 | Destination: 0 W, 1 file register |
| in_fdata | input | DATA_W (8) | Value read from the addressed file register |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| f_we | output | 1 | File register write enable |
| f_addr | output | ADDR_W (7) | File register write address |
| f_wdata | output | DATA_W (8) | File register write data |
| w_we | output | 1 | W write enable |
| w_wdata | output | DATA_W (8) | W write data |
| z_we | output | 1 | Zero flag update enable |
| z_val | output | 1 | New zero flag value |

## Verification
The bench builds the block with its default widths: an 8-bit data path and a 7-bit address. With 8 bits, the wrap of 00h to FFh on decrement and the all-ones input that inverts to zero are single values that directed commands hit on purpose. With 7 bits, random addresses cover the whole 0 to 127 range in a short run. Random gaps in `in_valid` and random stalls on `out_ready` put both the back-to-back path and the held-result path under comparison against the cycle model.

// File: rtl/fra_pkg.sv
package fra_pkg;
  typedef enum logic [1:0] {
    OP_CLR_F = 2'd0,
    OP_CLR_W = 2'd1,
    OP_INV   = 2'd2,
    OP_DEC   = 2'd3
  } fra_op_e;
endpackage

// File: rtl/fra_route.sv
// Destination decision: which register receives the result (R1..R4).
module fra_route
  import fra_pkg::*;
(
  input  fra_op_e op,
  input  logic    dest,
  output logic    to_file,
  output logic    to_w
);
  always_comb begin
    unique case (op)
      OP_CLR_F: to_w = 1'b0;
      OP_CLR_W: to_w = 1'b1;
      default:  to_w = ~dest;
    endcase
    to_file = ~to_w;
  end
endmodule

// File: rtl/fra_compute.sv
// Result value and zero detect (R1..R5).
module fra_compute
  import fra_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  fra_op_e           op,
  input  logic [DATA_W-1:0] fdata,
  output logic [DATA_W-1:0] result,
  output logic              zero
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  always_comb begin
    unique case (op)
      OP_CLR_F, OP_CLR_W: result = '0;
      OP_INV:             result = ~fdata;
      default:            result = fdata - ONE;
    endcase
    zero = (result == '0);
  end
endmodule

// File: rtl/fra_stage.sv
// One-entry result register with valid/ready on both sides (R8..R10).
module fra_stage #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              d_to_file,
  input  logic              d_to_w,
  input  logic [ADDR_W-1:0] d_addr,
  input  logic [DATA_W-1:0] d_data,
  input  logic              d_zero,
  output logic              q_valid,
  input  logic              q_ready,
  output logic              q_to_file,
  output logic              q_to_w,
  output logic [ADDR_W-1:0] q_addr,
  output logic [DATA_W-1:0] q_data,
  output logic              q_zero
);
  logic take;

  assign in_ready = ~q_valid | q_ready;
  assign take     = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
    end else if (take) begin
      q_valid <= 1'b1;
    end else if (q_ready) begin
      q_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_to_file <= 1'b0;
      q_to_w    <= 1'b0;
      q_addr    <= '0;
      q_data    <= '0;
      q_zero    <= 1'b0;
    end else if (take) begin
      q_to_file <= d_to_file;
      q_to_w    <= d_to_w;
      q_addr    <= d_addr;
      q_data    <= d_data;
      q_zero    <= d_zero;
    end
  end
endmodule

// File: rtl/fra_alu.sv
module fra_alu
  import fra_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        in_op,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic              in_dest,
  input  logic [DATA_W-1:0] in_fdata,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              f_we,
  output logic [ADDR_W-1:0] f_addr,
  output logic [DATA_W-1:0] f_wdata,
  output logic              w_we,
  output logic [DATA_W-1:0] w_wdata,
  output logic              z_we,
  output logic              z_val
);
  fra_op_e           op;
  logic              to_file, to_w, zero;
  logic [DATA_W-1:0] result;
  logic              q_to_file, q_to_w;
  logic [DATA_W-1:0] q_data;

  assign op = fra_op_e'(in_op);

  fra_route u_route (
    .op      (op),
    .dest    (in_dest),
    .to_file (to_file),
    .to_w    (to_w)
  );

  fra_compute #(.DATA_W(DATA_W)) u_compute (
    .op     (op),
    .fdata  (in_fdata),
    .result (result),
    .zero   (zero)
  );

  fra_stage #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .d_to_file (to_file),
    .d_to_w    (to_w),
    .d_addr    (in_addr),
    .d_data    (result),
    .d_zero    (zero),
    .q_valid   (out_valid),
    .q_ready   (out_ready),
    .q_to_file (q_to_file),
    .q_to_w    (q_to_w),
    .q_addr    (f_addr),
    .q_data    (q_data),
    .q_zero    (z_val)
  );

  assign f_we    = out_valid & q_to_file;
  assign w_we    = out_valid & q_to_w;
  assign z_we    = out_valid;
  assign f_wdata = q_data;
  assign w_wdata = q_data;
endmodule

// File: rtl/fra_alu_chk.sv
module fra_alu_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic              f_we,
  input logic [ADDR_W-1:0] f_addr,
  input logic [DATA_W-1:0] f_wdata,
  input logic              w_we,
  input logic [DATA_W-1:0] w_wdata,
  input logic              z_we,
  input logic              z_val
);
  a_r6_one_dest: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $countones({f_we, w_we}) == 1);

  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !(f_we || w_we || z_we));

  a_r5_zero_match: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> z_we && (z_val == (f_we ? (f_wdata == '0) : (w_wdata == '0))));

  a_r8_no_intake_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable({f_we, w_we, f_addr, f_wdata, z_val}));

  a_r10_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);
endmodule

bind fra_alu fra_alu_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_fra_alu.sv
`timescale 1ns/1ps
module sim_fra_alu;
  localparam int DW = 8;
  localparam int AW = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0, in_dest = 1'b0, out_ready = 1'b0;
  logic [1:0]    in_op = 2'd0;
  logic [AW-1:0] in_addr = '0;
  logic [DW-1:0] in_fdata = '0;
  logic          in_ready, out_valid, f_we, w_we, z_we, z_val;
  logic [AW-1:0] f_addr;
  logic [DW-1:0] f_wdata, w_wdata;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  fra_alu #(.DATA_W(DW), .ADDR_W(AW)) u0 (.*);

  // Reference model state
  bit      m_valid = 0, m_file = 0, m_z = 0;
  int      m_op = 0;
  int      m_data = 0, m_addr = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) m_valid <= 0;
    else if (in_valid && (!m_valid || out_ready)) begin
      int r;
      case (in_op)
        2'd0, 2'd1: r = 0;
        2'd2: r = (~int'(in_fdata)) & 8'hFF;
        default: r = (int'(in_fdata) + 255) % 256;
      endcase
      m_valid <= 1;
      m_op    <= int'(in_op);
      m_data  <= r;
      m_addr  <= int'(in_addr);
      m_z     <= (r == 0);
      m_file  <= (in_op == 2'd0) || (in_op[1] && in_dest);
    end else if (out_ready) m_valid <= 0;
  end

  task automatic compare();
    string t;
    t = (m_op == 0) ? "R1" : (m_op == 1) ? "R2" : (m_op == 2) ? "R3" : "R4";
    chk("R10 out_valid", int'(out_valid), int'(m_valid));
    chk("R8 in_ready", int'(in_ready), int'(!m_valid || out_ready));
    if (m_valid) begin
      chk({t, " dest"}, int'(f_we), int'(m_file));
      chk("R6 one_we", int'(f_we) + int'(w_we), 1);
      chk({t, " data"}, int'(m_file ? f_wdata : w_wdata), m_data);
      chk("R5 z_we", int'(z_we), 1);
      chk("R5 z_val", int'(z_val), int'(m_z));
      if (m_file) chk("R7 addr", int'(f_addr), m_addr);
    end else begin
      chk("R6 idle", int'({f_we, w_we, z_we}), 0);
    end
  endtask

  task automatic step(input bit v, input int op, input bit d, input int a, input int fd, input bit rdy);
    @(negedge clk);
    compare();
    in_valid = v; in_op = op[1:0]; in_dest = d;
    in_addr = a[AW-1:0]; in_fdata = fd[DW-1:0]; out_ready = rdy;
  endtask

  initial begin : watchdog
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset out_valid", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 after reset", int'(out_valid), 0);
    // Directed corners
    step(1, 0, 0, 5,   8'h37, 1);  // R1 clear file, d ignored
    step(1, 1, 1, 9,   8'h37, 1);  // R2 clear W, d ignored
    step(1, 2, 0, 10,  8'hA5, 1);  // R3 to W
    step(1, 2, 1, 127, 8'hFF, 1);  // R3 zero result
    step(1, 3, 1, 0,   8'h00, 1);  // R4 wrap to FF
    step(1, 3, 0, 64,  8'h01, 1);  // R4 zero result
    // R8 stall: result held while out_ready low
    step(1, 3, 1, 33,  8'h80, 0);
    step(1, 2, 1, 34,  8'h0F, 0);
    step(1, 2, 1, 34,  8'h0F, 0);
    step(1, 2, 1, 34,  8'h0F, 1);
    step(0, 0, 0, 0,   0,     1);
    // Random traffic
    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 4) != 0, int'($urandom % 4), 1'($urandom), int'($urandom % 128),
           int'($urandom % 256), ($urandom % 3) != 0);
    end
    step(0, 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule